// File: doc/BRIEF.md
# Timed-Unlock Nonvolatile Write Controller

This block fronts a small byte-wide nonvolatile store and protects it against stray writes. A CPU reaches it through three 8-bit registers chosen by a 2-bit select: a control register, a data register and an address register. A byte is committed only when software first arms the block and then, within a short window, raises the write strobe. Writes are also refused while an external flash-programming engine reports that it is busy.

An accepted write occupies the store for a programmable number of cycles. During that time the write strobe bit reads as 1. When the count ends, hardware stores the byte and clears the bit. A read strobe copies the byte at the current address into the data register in a single cycle. A level-type ready interrupt request is raised whenever the store is idle and both the local enable and the global interrupt enable input are 1.

Top module: `nvw_ctrl`

## Requirements
- R1: The control register holds the ready-interrupt enable in bit 3, the arm bit in bit 2, the write strobe/busy bit in bit 1 and the read strobe in bit 0. Bits 7..4 always read 0 and writes to them are ignored. After reset, all three registers read 0.
- R2: Writing 1 to bit 2 sets the arm bit and restarts its window. The bit reads 1 for ARM_WINDOW cycles and is then cleared by hardware. Writing 0 to bit 2 does not clear it.
- R3: A control write with bit 1 set starts a write when it comes 1 to ARM_WINDOW cycles after the arming write. One cycle later than that, it is refused. When bit 2 and bit 1 are written together while the arm bit was clear, no write starts.
- R4: Setting bit 1 while the arm bit is clear has no effect, and the stored byte is unchanged.
- R5: Setting bit 1 while flash_busy is high is ignored.
- R6: After an accepted write, bit 1 reads 1 for exactly WR_CYCLES cycles and then clears. At that point the data register byte is stored at the address register location.
- R7: Setting bit 0 loads the data register with the stored byte at the current address on the same clock edge. Bit 0 then reads 1 for one cycle.
- R8: rdy_irq equals interrupt enable AND gie AND NOT bit 1, as a continuous level.
- R9: While a write is in progress, the following are ignored: writes to the data and address registers, the read strobe, and writing 0 to bit 1.
- R10: Select code 0 addresses control, 1 addresses data and 2 addresses address. Code 3 reads 0 and ignores writes. The address register keeps the low ADDR_W bits of a write, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global interrupt enable |
| flash_busy | input | 1 | Flash programming in progress |
| rdy_irq | output | 1 | Ready interrupt request (level) |

## Verification
The bench builds the block with ADDR_W=4, WR_CYCLES=6 and ARM_WINDOW=4. The short write time lets many complete writes and readbacks fit in a short run. The 16-entry store lets address bytes above 15 show the truncation of the address register. Keeping the window at four cycles puts every strobe gap from one to five cycles within a few transactions.

// File: rtl/nvw_pkg.sv
`timescale 1ns/1ps
package nvw_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_NONE = 2'd3
  } nvw_sel_e;

  localparam int BIT_RD = 0;
  localparam int BIT_WR = 1;
  localparam int BIT_ME = 2;
  localparam int BIT_IE = 3;

  // control register image; upper nibble is hard zero
  function automatic logic [7:0] pack_ctrl(input logic ie, input logic me,
                                           input logic wr, input logic rd);
    return {4'b0000, ie, me, wr, rd};
  endfunction

  function automatic logic irq_level(input logic ie, input logic gie, input logic busy);
    return ie & gie & ~busy;
  endfunction

endpackage

// File: rtl/nvw_unlock.sv
`timescale 1ns/1ps
module nvw_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;
  logic          window_expire;

  assign window_expire = armed && !set_req && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (set_req) begin
      armed <= 1'b1;
      cnt   <= CW'(WINDOW - 1);
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - CW'(1);
    end
  end

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> armed);
  // R2
  no_spurious_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !set_req) |=> !armed);
  // R2
  arm_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_expire |=> !armed);

endmodule

// File: rtl/nvw_array.sv
`timescale 1ns/1ps
module nvw_array #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              busy,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [TW-1:0] cnt;
  logic          commit;

  assign commit  = busy && (cnt == TW'(1));
  assign rd_data = mem[addr];

  // contents survive reset
  always_ff @(posedge clk) begin
    if (commit) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= TW'(WR_CYCLES);
    end else if (busy) begin
      if (commit) busy <= 1'b0;
      else        cnt  <= cnt - TW'(1);
    end
  end

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R6
  end_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));
  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

endmodule

// File: rtl/nvw_bus_regs.sv
`timescale 1ns/1ps
module nvw_bus_regs
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nvw_sel_e          sel,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              armed,
  input  logic              busy,
  input  logic              flash_busy,
  input  logic [7:0]        rd_data,
  output logic              ie,
  output logic [7:0]        data_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              start,
  output logic              arm_req,
  output logic [7:0]        rdata
);
  logic       ctrl_wr, rd_req, data_wr, addr_wr, rd_flag;
  logic [7:0] addr_rd;

  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign arm_req = ctrl_wr && wdata[BIT_ME];
  assign start   = ctrl_wr && wdata[BIT_WR] && armed && !flash_busy && !busy;
  assign rd_req  = ctrl_wr && wdata[BIT_RD] && !busy && !start;
  assign data_wr = wr && (sel == SEL_DATA) && !busy;
  assign addr_wr = wr && (sel == SEL_ADDR) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      rd_flag <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (ctrl_wr) ie <= wdata[BIT_IE];
      rd_flag <= rd_req;
      if (rd_req)       data_q <= rd_data;
      else if (data_wr) data_q <= wdata;
      if (addr_wr) addr_q <= wdata[ADDR_W-1:0];
    end
  end

  generate
    if (ADDR_W < 8) begin : g_addr_pad
      assign addr_rd = {{(8 - ADDR_W){1'b0}}, addr_q};
    end else begin : g_addr_full
      assign addr_rd = addr_q;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_CTRL: rdata = pack_ctrl(ie, armed, busy, rd_flag);
      SEL_DATA: rdata = data_q;
      SEL_ADDR: rdata = addr_rd;
      default:  rdata = 8'h00;
    endcase
  end

  // R9
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q));
  // R9
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
  // R5
  flash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |-> !start);
  // R7
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (data_q == $past(rd_data)));

endmodule

// File: rtl/nvw_ctrl.sv
`timescale 1ns/1ps
module nvw_ctrl
  import nvw_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WR_CYCLES  = 16,
  parameter int ARM_WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       gie,
  input  logic       flash_busy,
  output logic       rdy_irq
);
  nvw_sel_e          sel_e;
  logic              armed, arm_req, start, busy, ie;
  logic [7:0]        data_q, rd_data;
  logic [ADDR_W-1:0] addr_q;

  assign sel_e   = nvw_sel_e'(bus_sel);
  assign rdy_irq = irq_level(ie, gie, busy);

  nvw_unlock #(.WINDOW(ARM_WINDOW)) u_unlock (
    .clk(clk), .rst_n(rst_n), .set_req(arm_req), .armed(armed)
  );

  nvw_array #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr_q),
    .wdata(data_q), .busy(busy), .rd_data(rd_data)
  );

  nvw_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel_e), .wr(bus_wr), .wdata(bus_wdata),
    .armed(armed), .busy(busy), .flash_busy(flash_busy), .rd_data(rd_data),
    .ie(ie), .data_q(data_q), .addr_q(addr_q), .start(start),
    .arm_req(arm_req), .rdata(bus_rdata)
  );

  // R8
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdy_irq);
  // R4
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> armed);

endmodule

// File: tb/nvw_ctrl_tb.sv
`timescale 1ns/1ps
module nvw_ctrl_tb;
  localparam int AW = 4, WC = 6, WIN = 4;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd3;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic gie = 1'b0, flash_busy = 1'b0, rdy_irq;

  always #10 clk = ~clk;

  nvw_ctrl #(.ADDR_W(AW), .WR_CYCLES(WC), .ARM_WINDOW(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie(gie),
    .flash_busy(flash_busy), .rdy_irq(rdy_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int m_ie, m_me, m_mc, m_busy, m_wc, m_rd, m_data, m_addr, ie_b;
  int mm [DEP];
  int pq [$];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input int s, input int w, input int d, input int fb);
    int o_me, o_busy, cw, acc, rdq, e;
    o_me = m_me; o_busy = m_busy;
    cw  = (w != 0 && s == 0);
    acc = cw && d[1] && o_me != 0 && fb == 0 && o_busy == 0;
    rdq = cw && d[0] && o_busy == 0 && !acc;
    if (cw && d[2]) begin m_me = 1; m_mc = WIN - 1; end
    else if (o_me != 0) begin if (m_mc == 0) m_me = 0; else m_mc--; end
    if (o_busy != 0) begin
      if (m_wc == 1) begin
        e = pq.pop_front(); mm[e / 256] = e % 256; m_busy = 0;
      end else m_wc--;
    end else if (acc) begin
      m_busy = 1; m_wc = WC; pq.push_back(m_addr * 256 + m_data);
    end
    m_rd = rdq;
    if (rdq) m_data = mm[m_addr];
    else if (w != 0 && s == 1 && o_busy == 0) m_data = d;
    if (w != 0 && s == 2 && o_busy == 0) m_addr = d % DEP;
    if (cw) m_ie = d[3];
  endtask

  task automatic peek_all();
    chk("R8 irq level", int'(rdy_irq), int'(m_ie != 0 && gie && m_busy == 0));
    bus_wr = 1'b0;
    bus_sel = 2'd0; #1;
    chk("R1 reserved nibble", int'(bus_rdata[7:4]), 0);
    chk("R1 ie bit", int'(bus_rdata[3]), m_ie);
    chk("R2 arm bit", int'(bus_rdata[2]), m_me);
    chk("R6 busy bit", int'(bus_rdata[1]), m_busy);
    chk("R7 read strobe bit", int'(bus_rdata[0]), m_rd);
    bus_sel = 2'd1; #1;
    chk("R7 data reg", int'(bus_rdata), m_data);
    bus_sel = 2'd2; #1;
    chk("R10 addr reg", int'(bus_rdata), m_addr);
    bus_sel = 2'd3; #1;
    chk("R10 unused select", int'(bus_rdata), 0);
  endtask

  task automatic cyc(input int s, input int w, input int d);
    bus_sel = 2'(s); bus_wr = (w != 0); bus_wdata = 8'(d);
    @(posedge clk);
    model_step(s, w, d, int'(flash_busy));
    @(negedge clk);
    peek_all();
  endtask

  task automatic wreg(input int s, input int d); cyc(s, 1, d); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(3, 0, 0); endtask

  task automatic rd_reg(input int s, output int v);
    bus_wr = 1'b0; bus_sel = 2'(s); #1; v = int'(bus_rdata);
  endtask

  // arm, wait so the strobe lands gap cycles later, strobe; returns busy bit
  task automatic try_write(input int a, input int d, input int gap, output int b);
    int v;
    wreg(2, a); wreg(1, d); wreg(0, ie_b | 4);
    idle(gap - 1);
    wreg(0, ie_b | 2);
    rd_reg(0, v); b = v[1];
  endtask

  task automatic read_at(input int a, output int v);
    wreg(2, a); wreg(0, ie_b | 1);
    rd_reg(1, v);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b, v;
    m_ie = 0; m_me = 0; m_mc = 0; m_busy = 0; m_wc = 0; m_rd = 0;
    m_data = 0; m_addr = 0; ie_b = 0;
    for (int i = 0; i < DEP; i++) mm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek_all();   // R1 reset state

    // R3 gaps 1..4 accepted, each followed by R6 completion and R7 readback
    for (int g = 1; g <= 4; g++) begin
      try_write(g, 8'h50 + g, g, b);
      chk($sformatf("R3 gap=%0d accepted", g), b, 1);
      idle(WC);
      rd_reg(0, v); chk("R6 busy cleared after count", v[1], 0);
      read_at(g, v);
      chk($sformatf("R7 readback addr %0d", g), v, 8'h50 + g);
    end
    // R3 gap 5 refused; byte unchanged
    try_write(1, 8'h3C, 5, b);
    chk("R3 gap=5 refused", b, 0);
    idle(2); read_at(1, v); chk("R3 refused write leaves byte", v, 8'h51);

    // R4 strobe without arming
    wreg(2, 2); wreg(1, 8'hEE); wreg(0, 2);
    rd_reg(0, v); chk("R4 no arm no start", v[1], 0);
    read_at(2, v); chk("R4 byte unchanged", v, 8'h52);

    // R3 arm and strobe in same write while disarmed
    idle(6); wreg(1, 8'h77); wreg(0, 6);
    rd_reg(0, v); chk("R3 same-write arm+strobe refused", v[1], 0);
    // R3 arm+strobe together when already armed: accepted
    wreg(0, 6);
    rd_reg(0, v); chk("R3 armed arm+strobe accepted", v[1], 1);
    // R9 ignored during write
    wreg(1, 8'h11); wreg(2, 9); wreg(0, 1); wreg(0, 0);
    rd_reg(0, v); chk("R9 strobe 0 does not abort", v[1], 1);
    rd_reg(1, v); chk("R9 data reg held", v, 8'h77);
    rd_reg(2, v); chk("R9 addr reg held", v, 2);
    idle(WC);
    read_at(2, v); chk("R6 committed byte", v, 8'h77);

    // R2 writing 0 to arm bit does not clear it
    wreg(0, 4); wreg(0, 0);
    rd_reg(0, v); chk("R2 arm survives zero write", v[2], 1);
    idle(4);
    rd_reg(0, v); chk("R2 arm self-cleared", v[2], 0);

    // R5 flash busy blocks
    flash_busy = 1'b1;
    try_write(5, 8'h99, 2, b);
    chk("R5 flash busy refuses", b, 0);
    flash_busy = 1'b0; idle(5);
    read_at(5, v); chk("R5 byte unchanged", v, 8'h00);

    // R8 irq follows enable, gie and busy
    ie_b = 8; wreg(0, 8); gie = 1'b0; #1;
    chk("R8 irq off with gie=0", int'(rdy_irq), 0);
    gie = 1'b1; #1;
    chk("R8 irq on when idle", int'(rdy_irq), 1);
    try_write(6, 8'hC3, 3, b);
    chk("R8 irq off while busy", int'(rdy_irq), 0);
    idle(WC);
    chk("R8 irq back on", int'(rdy_irq), 1);
    read_at(6, v); chk("R7 readback 6", v, 8'hC3);

    // R1 reserved bits, R10 truncation and unused select
    wreg(0, 8'hF8);
    rd_reg(0, v); chk("R1 upper bits read 0", v, 8);
    wreg(2, 8'hF7); rd_reg(2, v); chk("R10 addr truncated", v, 7);
    wreg(3, 8'hAA); rd_reg(1, v); chk("R10 select 3 write ignored", v, m_data);
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule